// File: doc/BRIEF.md
# Power-Fail Store Handshake Controller

This block decides when a copy from the SRAM array into its nonvolatile shadow may start. It also drives a shared, open-drain store-busy line that other devices on the board can see and can override. A store attempt comes from one of two sources:

- a falling supply, seen as a synchronous low-supply flag rising, while automatic store is enabled;
- an external request, which is accepted only while the supply is good.

Every attempt begins the same way. The controller pulls the shared line low for a fixed window. An external driver may hold the line high to veto the store. If the synchronized line reads low at least once during the window, the store goes ahead: the block issues a one-cycle start pulse and stays busy for a fixed store time. If the line never reads low, the block releases the line, issues a one-cycle abort pulse and goes back to idle.

SRAM writes are held off while the supply is low and while an attempt or a store is under way.

The controller has three states:

| State | Meaning |
|---|---|
| `ST_IDLE` | No attempt under way. |
| `ST_PULL` | The pull-down window is open. |
| `ST_STORE` | The modelled store is running. |

Its transitions are:

| Transition | Condition |
|---|---|
| `IDLE->PULL` | An automatic trigger is pending, or an external request arrives while the supply is good. |
| `PULL->STORE` | The window ends and the line was seen low. This raises the start pulse. |
| `PULL->IDLE` | The window ends and the line was never seen low. This raises the abort pulse. |
| `STORE->IDLE` | The store time has elapsed. |

Top module: `pfs_store_ctrl`

## Requirements
- R1: After reset the pull-down enable, the start pulse and the abort pulse are low, and the write inhibit is low while the supply flag is low.
- R2: With automatic store enabled, a rising low-supply flag seen in idle opens a pull-down window: `busy_pull_en` stays high for exactly PULL_CYC cycles.
- R3: If the synchronized busy line reads 0 at least once during the window, `store_start` is high for exactly one cycle, in the cycle after the window ends. The block then stays busy for STORE_CYC cycles, and never raises abort for that attempt.
- R4: If the synchronized busy line stays 1 for the whole window, `store_abort` is high for exactly one cycle after the window ends, no `store_start` follows, and the block returns to idle.
- R5: An `ext_req` sampled high in idle while `supply_low` is 0 starts the same window-then-store sequence.
- R6: An `ext_req` sampled while `supply_low` is 1 is ignored: no window opens, and neither pulse appears.
- R7: `wr_inhibit` is high whenever `supply_low` is 1, and also throughout the window and the store. With a good supply and no attempt under way it is low.
- R8: Only the first crossing counts. After one automatic attempt, no further automatic attempt starts while `supply_low` stays 1. A recovery to 0 followed by a new rise arms it again.
- R9: With `auto_en` at 0, a rising `supply_low` opens no window.
- R10: A supply crossing that occurs while an attempt or store is under way is held pending. It starts its own window once the block returns to idle, as long as the supply is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_low | input | 1 | Synchronous flag: supply below the switch threshold |
| auto_en | input | 1 | 1 = a supply crossing triggers an automatic store |
| ext_req | input | 1 | External store request, sampled each cycle |
| busy_line_in | input | 1 | Raw level of the shared store-busy line (1 = released/high) |
| busy_pull_en | output | 1 | 1 = pull the shared busy line low |
| store_start | output | 1 | One-cycle pulse: store begins |
| store_abort | output | 1 | One-cycle pulse: attempt abandoned |
| wr_inhibit | output | 1 | 1 = SRAM writes must be blocked |

## Verification
The bench builds the block with a pull window of 8 cycles and a store time of 12 cycles. With these values a whole attempt lasts only a few tens of cycles, so its exact duration can be counted cycle by cycle. The window is also longer than the two-flop synchronizer latency, so an unobstructed line is seen low inside it. The shared line is modelled as a pulled-up wire that the bench can force high, which makes both the veto case and the normal handshake reachable.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULL  = 2'd1,
        ST_STORE = 2'd2
    } pfs_state_e;

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pfs_timer.sv
module pfs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R3 (window and store durations rely on a steady countdown)
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !done) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pfs_trigger.sv
module pfs_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic auto_en,
    input  logic taken,
    output logic auto_go
);
    logic low_q;
    logic armed;
    logic pend;
    logic crossing;

    assign crossing = supply_low & ~low_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= 1'b0;
            armed <= 1'b1;
            pend  <= 1'b0;
        end else begin
            low_q <= supply_low;
            if (!supply_low) begin
                armed <= 1'b1;
                pend  <= 1'b0;
            end else if (crossing && auto_en && armed) begin
                armed <= 1'b0;
                pend  <= 1'b1;
            end else if (taken) begin
                pend  <= 1'b0;
            end
        end
    end

    assign auto_go = pend;

    // R8
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $fell(armed));

    // R9
    auto_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(auto_en));
endmodule

// File: rtl/pfs_store_ctrl.sv
module pfs_store_ctrl
    import pfs_pkg::*;
#(
    parameter int PULL_CYC    = 1000,
    parameter int STORE_CYC   = 10000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic auto_en,
    input  logic ext_req,
    input  logic busy_line_in,
    output logic busy_pull_en,
    output logic store_start,
    output logic store_abort,
    output logic wr_inhibit
);
    localparam int LONGEST = (PULL_CYC > STORE_CYC) ? PULL_CYC : STORE_CYC;
    localparam int CW      = (LONGEST > 1) ? $clog2(LONGEST) : 1;
    localparam logic [CW-1:0] PULL_LOAD  = CW'(PULL_CYC - 1);
    localparam logic [CW-1:0] STORE_LOAD = CW'(STORE_CYC - 1);

    pfs_state_e state, nxt;

    logic line_s;
    logic line_low;
    logic seen_low;
    logic proceed;
    logic auto_go;
    logic ext_go;
    logic begin_att;
    logic t_done;
    logic t_load;
    logic [CW-1:0] t_val;

    pfs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (busy_line_in),
        .q     (line_s)
    );

    pfs_trigger u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_low (supply_low),
        .auto_en    (auto_en),
        .taken      ((state == ST_IDLE) && auto_go),
        .auto_go    (auto_go)
    );

    pfs_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    assign line_low  = ~line_s;
    assign proceed   = seen_low | line_low;
    assign ext_go    = ext_req & ~supply_low;
    assign begin_att = auto_go | ext_go;

    always_comb begin
        t_load = 1'b0;
        t_val  = PULL_LOAD;
        if (state == ST_IDLE && begin_att) begin
            t_load = 1'b1;
            t_val  = PULL_LOAD;
        end else if (state == ST_PULL && t_done && proceed) begin
            t_load = 1'b1;
            t_val  = STORE_LOAD;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (begin_att) nxt = ST_PULL;
            ST_PULL:  if (t_done)    nxt = proceed ? ST_STORE : ST_IDLE;
            ST_STORE: if (t_done)    nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 seen_low <= 1'b0;
        else if (state != ST_PULL)  seen_low <= 1'b0;
        else if (line_low)          seen_low <= 1'b1;
    end

    // Outputs: level outputs follow the state, pulses mark the window exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_start <= 1'b0;
            store_abort <= 1'b0;
        end else begin
            store_start <= (state == ST_PULL) && t_done &&  proceed;
            store_abort <= (state == ST_PULL) && t_done && !proceed;
        end
    end

    assign busy_pull_en = (state == ST_PULL);
    assign wr_inhibit   = supply_low | (state != ST_IDLE);

    // R3
    start_after_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_start |-> $past(busy_pull_en) && !busy_pull_en);

    // R3
    start_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_start |-> $past(proceed));

    // R4
    abort_after_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_abort |-> $past(busy_pull_en) && !$past(seen_low) && !store_start);

    // R6
    low_blocks_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && supply_low && !auto_go) |=> !busy_pull_en);

    // R7
    inhibit_in_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_pull_en |-> wr_inhibit);
endmodule

// File: tb/tb_pfs_store_ctrl.sv
`timescale 1ns/1ps
module tb_pfs_store_ctrl;
    localparam int PULL  = 8;
    localparam int STORE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b0;
    logic auto_en = 1'b0;
    logic ext_req = 1'b0;
    logic hold_high = 1'b0;
    logic busy_line;
    logic busy_pull_en, store_start, store_abort, wr_inhibit;

    int checks = 0;
    int fails  = 0;
    int pull_cnt, start_cnt, abort_cnt, inh_cnt;

    always #10 clk = ~clk;

    // Open-drain line with pull-up; an external driver can force it high.
    assign busy_line = hold_high | ~busy_pull_en;

    pfs_store_ctrl #(.PULL_CYC(PULL), .STORE_CYC(STORE)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_low   (supply_low),
        .auto_en      (auto_en),
        .ext_req      (ext_req),
        .busy_line_in (busy_line),
        .busy_pull_en (busy_pull_en),
        .store_start  (store_start),
        .store_abort  (store_abort),
        .wr_inhibit   (wr_inhibit)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            pull_cnt  <= pull_cnt  + int'(busy_pull_en);
            start_cnt <= start_cnt + int'(store_start);
            abort_cnt <= abort_cnt + int'(store_abort);
            inh_cnt   <= inh_cnt   + int'(wr_inhibit);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr();
        @(posedge clk); #2;
        pull_cnt = 0; start_cnt = 0; abort_cnt = 0; inh_cnt = 0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_ext();
        @(posedge clk); #2 ext_req = 1'b1;
        @(posedge clk); #2 ext_req = 1'b0;
    endtask

    task automatic t_reset();
        cycles(3);
        chk("R1 pull", int'(busy_pull_en), 0);
        chk("R1 start", int'(store_start), 0);
        chk("R1 abort", int'(store_abort), 0);
        chk("R1 inhibit", int'(wr_inhibit), 0);
    endtask

    task automatic t_power_fail_store();
        auto_en = 1'b1;
        clr();
        supply_low = 1'b1;
        cycles(60);
        chk("R2 window length", pull_cnt, PULL);
        chk("R3 one start", start_cnt, 1);
        chk("R3 no abort", abort_cnt, 0);
        chk("R8 no second attempt", pull_cnt, PULL);
        chk("R7 inhibit while low", int'(wr_inhibit), 1);
        supply_low = 1'b0;
        cycles(4);
        chk("R7 inhibit released", int'(wr_inhibit), 0);
        clr();
        supply_low = 1'b1;
        cycles(60);
        chk("R8 rearmed attempt", pull_cnt, PULL);
        chk("R8 rearmed start", start_cnt, 1);
        supply_low = 1'b0;
        auto_en = 1'b0;
        cycles(4);
    endtask

    task automatic t_abort_high_driver();
        hold_high = 1'b1;
        clr();
        pulse_ext();
        cycles(40);
        chk("R4 window opened", pull_cnt, PULL);
        chk("R4 one abort", abort_cnt, 1);
        chk("R4 no start", start_cnt, 0);
        chk("R7 inhibit only in window", inh_cnt, PULL);
        hold_high = 1'b0;
        cycles(2);
    endtask

    task automatic t_ext_store();
        clr();
        pulse_ext();
        cycles(50);
        chk("R5 window", pull_cnt, PULL);
        chk("R5 start", start_cnt, 1);
        chk("R3 busy time", inh_cnt, PULL + STORE);
        chk("R5 no abort", abort_cnt, 0);
    endtask

    task automatic t_ext_rejected_low();
        auto_en = 1'b0;
        clr();
        supply_low = 1'b1;
        cycles(10);
        chk("R9 no auto window", pull_cnt, 0);
        pulse_ext();
        cycles(30);
        chk("R6 no window", pull_cnt, 0);
        chk("R6 no start", start_cnt, 0);
        chk("R6 no abort", abort_cnt, 0);
        chk("R7 inhibit low supply", int'(wr_inhibit), 1);
        supply_low = 1'b0;
        cycles(4);
    endtask

    task automatic t_pending_crossing();
        clr();
        pulse_ext();
        cycles(12);
        auto_en = 1'b1;
        supply_low = 1'b1;
        cycles(70);
        chk("R10 two windows", pull_cnt, 2 * PULL);
        chk("R10 two starts", start_cnt, 2);
        supply_low = 1'b0;
        auto_en = 1'b0;
        cycles(4);
    endtask

    initial begin
        pull_cnt = 0; start_cnt = 0; abort_cnt = 0; inh_cnt = 0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_power_fail_store();
        t_abort_high_driver();
        t_ext_store();
        t_ext_rejected_low();
        t_pending_crossing();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule